// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block sits between a UART's receive FIFO and its transmit shift logic and handles hardware handshaking for both directions. On the receive side it drives the active-low request-to-send pin. In automatic mode the pin is set from the receive FIFO fill count, with hysteresis between two trigger levels. In manual mode the pin follows a software control bit. On the transmit side it turns the clear-to-send input into a start permit for the transmitter. An automatic clear-to-send mode can stall new characters while the far end is not ready.

The unit takes an 8-bit control word from the UART's modem control register and decodes its fields itself. It also takes the FIFO count, a 2-bit trigger-level select, the raw clear-to-send pin and a simple request/idle handshake from the transmitter. It returns the pin, the value that software reads back for its RTS control bit, and a one-signal start grant. The clear-to-send pin is resynchronised internally. The unit never gates reception, so a byte the far end has already started after RTS is cut still lands in the FIFO. A diagnostic loopback mode holds the external pin inactive and routes the internal RTS state back as the internal CTS.

Top module: `uart_flow_ctrl`

## Requirements
- R1: Control word decode: bit 1 is the software RTS request (1 = assert), bit 4 selects loopback, bit 6 enables automatic RTS, bit 7 enables automatic CTS. Bit 5 and bits 0, 2, 3 have no effect on any output.
- R2: While reset is low, and until the first clock after it, rts_n is 1 and rts_rd is 0.
- R3: Trigger select 0, 1, 2, 3 picks an upper level of 1, 4, 8, 14 entries. With automatic RTS on, a count at or above the upper level deasserts RTS (rts_n = 1) on the next clock.
- R4: With automatic RTS on, a deasserted RTS stays deasserted while the count is above the lower level. The lower level is 0, 1, 4 and 8 for selects 0 to 3. RTS reasserts on the clock after the count is at or below the lower level.
- R5: With automatic RTS off, the internal RTS state takes the software request bit on each clock, and rts_n is its inverse (outside loopback).
- R6: With automatic RTS on, rts_rd shows the hardware RTS state (1 = asserted) and the software request bit has no effect on rts_n or rts_rd. With it off, rts_rd equals the software bit.
- R7: cts_n passes through a two-stage synchroniser: a change on the pin reaches tx_start after the second rising clock edge.
- R8: With automatic CTS on (not loopback), tx_start is 1 only when the synchronised cts_n is 0, tx_pending is 1 and tx_idle is 1. A character in flight (tx_idle = 0) is never interrupted and gets no new start.
- R9: With automatic CTS off, tx_start equals tx_pending AND tx_idle whatever cts_n is.
- R10: In loopback, rts_n is held at 1 and the internal RTS state (1 = asserted) replaces the external clear-to-send for the start permit. cts_n is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 8 | Modem control word (fields in R1) |
| trig_sel | input | 2 | Receive trigger-level select |
| rx_count | input | CNT_W | Receive FIFO fill count |
| cts_n | input | 1 | Raw clear-to-send pin, active low |
| tx_pending | input | 1 | Transmitter has a character waiting |
| tx_idle | input | 1 | Transmit shifter is idle |
| rts_n | output | 1 | Request-to-send pin, active low |
| rts_rd | output | 1 | Readback value of the RTS control bit |
| tx_start | output | 1 | Grant to start the next character |

## Verification
The FIFO count is driven as a random walk of one step at a time, so it crosses each trigger level from above and from below. This separates the hysteresis band from a plain threshold compare. Directed runs sweep the count through levels 4 and 1 and show that the pin holds between the lower and upper level instead of toggling. The software bit is toggled in both modes, which separates "follows the bit" from "ignores the bit". The CTS tests step the pin one edge at a time to fix the latency at two clocks. They also drop tx_idle and enable loopback with the external pin held inactive, so the internal RTS path is shown to drive the grant.

// File: rtl/uflow_pkg.sv
package uflow_pkg;

  localparam int unsigned BIT_RTS_SW = 1;
  localparam int unsigned BIT_LOOP   = 4;
  localparam int unsigned BIT_ARTS   = 7 - 1;
  localparam int unsigned BIT_ACTS   = 7;

  typedef struct packed {
    logic auto_cts;
    logic auto_rts;
    logic loopback;
    logic rts_sw;
  } flow_ctrl_t;

  function automatic flow_ctrl_t decode_ctrl(input logic [7:0] word);
    flow_ctrl_t f;
    f.auto_cts = word[BIT_ACTS];
    f.auto_rts = word[BIT_ARTS];
    f.loopback = word[BIT_LOOP];
    f.rts_sw   = word[BIT_RTS_SW];
    return f;
  endfunction

endpackage

// File: rtl/uflow_level_sel.sv
module uflow_level_sel #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LVL_A = 1,
  parameter int unsigned LVL_B = 4,
  parameter int unsigned LVL_C = 8,
  parameter int unsigned LVL_D = 14
) (
  input  logic [1:0]       trig_sel,
  output logic [CNT_W-1:0] hi_lvl,
  output logic [CNT_W-1:0] lo_lvl
);

  localparam logic [CNT_W-1:0] HA = CNT_W'(LVL_A);
  localparam logic [CNT_W-1:0] HB = CNT_W'(LVL_B);
  localparam logic [CNT_W-1:0] HC = CNT_W'(LVL_C);
  localparam logic [CNT_W-1:0] HD = CNT_W'(LVL_D);

  always_comb begin
    unique case (trig_sel)
      2'd0: begin hi_lvl = HA; lo_lvl = '0; end
      2'd1: begin hi_lvl = HB; lo_lvl = HA; end
      2'd2: begin hi_lvl = HC; lo_lvl = HB; end
      default: begin hi_lvl = HD; lo_lvl = HC; end
    endcase
  end

endmodule

// File: rtl/uflow_rts_hyst.sv
module uflow_rts_hyst #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             sw_req,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] hi_lvl,
  input  logic [CNT_W-1:0] lo_lvl,
  output logic             rts_on
);

  logic on_d;
  logic on_q;
  logic at_high;
  logic at_low;

  assign at_high = (rx_count >= hi_lvl);
  assign at_low  = (rx_count <= lo_lvl);

  always_comb begin
    on_d = on_q;
    if (!auto_en) begin
      on_d = sw_req;
    end else if (on_q) begin
      if (at_high) on_d = 1'b0;
    end else begin
      if (at_low) on_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_d;
  end

  assign rts_on = on_q;

endmodule

// File: rtl/uflow_sync.sv
module uflow_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d[0] = din;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      assign chain_d[i] = chain_q[i-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/uflow_tx_gate.sv
module uflow_tx_gate (
  input  logic auto_cts,
  input  logic loopback,
  input  logic ext_cts_n,
  input  logic rts_on,
  input  logic tx_pending,
  input  logic tx_idle,
  output logic tx_start
);

  logic peer_ready;
  logic permit;

  always_comb begin
    if (loopback) peer_ready = rts_on;
    else          peer_ready = ~ext_cts_n;
    permit   = ~auto_cts | peer_ready;
    tx_start = permit & tx_pending & tx_idle;
  end

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uflow_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned CNT_W       = $clog2(FIFO_DEPTH + 1),
  parameter int unsigned LVL_A       = 1,
  parameter int unsigned LVL_B       = 4,
  parameter int unsigned LVL_C       = 8,
  parameter int unsigned LVL_D       = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ctrl,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             cts_n,
  input  logic             tx_pending,
  input  logic             tx_idle,
  output logic             rts_n,
  output logic             rts_rd,
  output logic             tx_start
);

  flow_ctrl_t       fc;
  logic [CNT_W-1:0] hi_lvl;
  logic [CNT_W-1:0] lo_lvl;
  logic             rts_on;
  logic             cts_sync_n;

  assign fc = decode_ctrl(ctrl);

  uflow_level_sel #(
    .CNT_W(CNT_W), .LVL_A(LVL_A), .LVL_B(LVL_B), .LVL_C(LVL_C), .LVL_D(LVL_D)
  ) u_lvl (
    .trig_sel(trig_sel),
    .hi_lvl  (hi_lvl),
    .lo_lvl  (lo_lvl)
  );

  uflow_rts_hyst #(.CNT_W(CNT_W)) u_rts (
    .clk     (clk),
    .rst_n   (rst_n),
    .auto_en (fc.auto_rts),
    .sw_req  (fc.rts_sw),
    .rx_count(rx_count),
    .hi_lvl  (hi_lvl),
    .lo_lvl  (lo_lvl),
    .rts_on  (rts_on)
  );

  uflow_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cts_n),
    .dout (cts_sync_n)
  );

  uflow_tx_gate u_gate (
    .auto_cts  (fc.auto_cts),
    .loopback  (fc.loopback),
    .ext_cts_n (cts_sync_n),
    .rts_on    (rts_on),
    .tx_pending(tx_pending),
    .tx_idle   (tx_idle),
    .tx_start  (tx_start)
  );

  assign rts_n  = fc.loopback ? 1'b1 : ~rts_on;
  assign rts_rd = fc.auto_rts ? rts_on : fc.rts_sw;

endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk #(
  parameter int unsigned CNT_W       = 5,
  parameter int unsigned LVL_A       = 1,
  parameter int unsigned LVL_B       = 4,
  parameter int unsigned LVL_C       = 8,
  parameter int unsigned LVL_D       = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ctrl,
  input logic [1:0]       trig_sel,
  input logic [CNT_W-1:0] rx_count,
  input logic             cts_n,
  input logic             tx_pending,
  input logic             tx_idle,
  input logic             rts_n,
  input logic             rts_on,
  input logic             tx_start
);

  logic [CNT_W-1:0] hi;
  logic [CNT_W-1:0] lo;

  always_comb begin
    case (trig_sel)
      2'd0: begin hi = CNT_W'(LVL_A); lo = '0; end
      2'd1: begin hi = CNT_W'(LVL_B); lo = CNT_W'(LVL_A); end
      2'd2: begin hi = CNT_W'(LVL_C); lo = CNT_W'(LVL_B); end
      default: begin hi = CNT_W'(LVL_D); lo = CNT_W'(LVL_C); end
    endcase
  end

  AST_RTS_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && rx_count >= hi) |=> !rts_on); // R3

  AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && !rts_on && rx_count > lo) |=> !rts_on); // R4

  AST_RTS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && !rts_on && rx_count <= lo) |=> rts_on); // R4

  AST_SW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[6] |=> (rts_on == $past(ctrl[1]))); // R5

  AST_LB_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[4] |-> rts_n); // R10

  AST_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && tx_pending && tx_idle) |-> tx_start); // R9

  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_idle && tx_pending)); // R8

  generate
    if (SYNC_STAGES == 2) begin : g_cts_lat
      AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[7] && !ctrl[4] && tx_start) |-> !$past(cts_n, 2)); // R7
    end
  endgenerate

endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(
  .CNT_W(CNT_W), .LVL_A(LVL_A), .LVL_B(LVL_B), .LVL_C(LVL_C), .LVL_D(LVL_D),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl      (ctrl),
  .trig_sel  (trig_sel),
  .rx_count  (rx_count),
  .cts_n     (cts_n),
  .tx_pending(tx_pending),
  .tx_idle   (tx_idle),
  .rts_n     (rts_n),
  .rts_on    (rts_on),
  .tx_start  (tx_start)
);

// File: tb/sim_uart_flow_ctrl.sv
`timescale 1ns/1ps
module sim_uart_flow_ctrl;

  localparam int CNT_W = 5;
  localparam int MAXC  = 16;

  logic             clk;
  logic             rst_n;
  logic [7:0]       ctrl;
  logic [1:0]       trig_sel;
  logic [CNT_W-1:0] rx_count;
  logic             cts_n;
  logic             tx_pending;
  logic             tx_idle;
  logic             rts_n;
  logic             rts_rd;
  logic             tx_start;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  uart_flow_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .trig_sel(trig_sel),
    .rx_count(rx_count), .cts_n(cts_n), .tx_pending(tx_pending),
    .tx_idle(tx_idle), .rts_n(rts_n), .rts_rd(rts_rd), .tx_start(tx_start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int hi_of(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic int lo_of(input logic [1:0] s);
    case (s) 2'd0: return 0; 2'd1: return 1; 2'd2: return 4; default: return 8; endcase
  endfunction

  // reference state from the requirements
  logic m_on, m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on <= 1'b0; m_s1 <= 1'b1; m_s2 <= 1'b1;
    end else begin
      m_s1 <= cts_n;
      m_s2 <= m_s1;
      if (!ctrl[6])                                 m_on <= ctrl[1];
      else if (m_on && int'(rx_count) >= hi_of(trig_sel))  m_on <= 1'b0;
      else if (!m_on && int'(rx_count) <= lo_of(trig_sel)) m_on <= 1'b1;
    end
  end

  function automatic logic exp_start();
    logic ready;
    ready = ctrl[4] ? m_on : ~m_s2;
    return tx_pending & tx_idle & (~ctrl[7] | ready);
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic model_check();
    chk(ctrl[4] ? "R10" : (ctrl[6] ? "R4" : "R5"), "rts_n", rts_n, ctrl[4] ? 1'b1 : ~m_on);
    chk("R6", "rts_rd", rts_rd, ctrl[6] ? m_on : ctrl[1]);
    chk(ctrl[7] ? "R8" : "R9", "tx_start", tx_start, exp_start());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ctrl = 8'h00; trig_sel = 2'd0; rx_count = '0;
    cts_n = 1'b1; tx_pending = 1'b0; tx_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "rts_n in reset", rts_n, 1'b1);
    chk("R2", "rts_rd in reset", rts_rd, 1'b0);
    rst_n = 1'b1;

    // R1: reserved bit 5 set along with software request
    ctrl = 8'h22; tick();
    chk("R1", "rts_n with bit5+bit1", rts_n, 1'b0);
    chk("R1", "rts_rd with bit5+bit1", rts_rd, 1'b1);

    // R3/R4 hysteresis at select 1 (levels 4 / 1)
    ctrl = 8'h40; trig_sel = 2'd1; rx_count = 5'd0; tick();
    chk("R6", "rts_rd mirrors hw while sw=0", rts_rd, 1'b1);
    rx_count = 5'd3; tick();
    chk("R3", "below upper level", rts_n, 1'b0);
    rx_count = 5'd4; tick();
    chk("R3", "at upper level 4", rts_n, 1'b1);
    chk("R6", "rts_rd after cut", rts_rd, 1'b0);
    ctrl = 8'h42; rx_count = 5'd5; tick();
    chk("R6", "sw write ignored pin", rts_n, 1'b1);
    chk("R6", "sw write ignored rd", rts_rd, 1'b0);
    rx_count = 5'd2; tick();
    chk("R4", "inside band holds", rts_n, 1'b1);
    rx_count = 5'd1; tick();
    chk("R4", "back at lower level 1", rts_n, 1'b0);
    trig_sel = 2'd0; tick();
    chk("R3", "select 0 level 1 cut", rts_n, 1'b1);
    rx_count = 5'd0; tick();
    chk("R4", "select 0 reassert at empty", rts_n, 1'b0);

    // R7/R8 CTS latency and gating
    ctrl = 8'h80; tx_pending = 1'b1; tx_idle = 1'b1; cts_n = 1'b1;
    repeat (3) tick();
    chk("R8", "blocked by cts high", tx_start, 1'b0);
    cts_n = 1'b0; tick();
    chk("R7", "one edge after cts low", tx_start, 1'b0);
    tick();
    chk("R7", "two edges after cts low", tx_start, 1'b1);
    tx_idle = 1'b0; tick();
    chk("R8", "busy shifter no start", tx_start, 1'b0);
    tx_idle = 1'b1; cts_n = 1'b1; tick();
    chk("R7", "one edge after cts high", tx_start, 1'b1);
    tick();
    chk("R7", "two edges after cts high", tx_start, 1'b0);
    ctrl = 8'h00; tick();
    chk("R9", "auto cts off ignores cts", tx_start, 1'b1);

    // R10 loopback
    ctrl = 8'h92; tick();
    chk("R10", "loopback pin held high", rts_n, 1'b1);
    chk("R10", "loopback internal cts grant", tx_start, 1'b1);
    ctrl = 8'h90; tick();
    chk("R10", "loopback internal cts block", tx_start, 1'b0);
    chk("R10", "loopback pin still high", rts_n, 1'b1);

    // random walk
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(19) == 0) ctrl = 8'($urandom) & 8'hF2 | 8'($urandom_range(1) << 5);
      if ($urandom_range(29) == 0) trig_sel = 2'($urandom);
      if ($urandom_range(1) == 0) begin
        if (int'(rx_count) < MAXC) rx_count = rx_count + 1'b1;
      end else if (rx_count != 0) rx_count = rx_count - 1'b1;
      if ($urandom_range(5) == 0) cts_n = ~cts_n;
      tx_pending = ($urandom_range(3) != 0);
      tx_idle    = ($urandom_range(2) != 0);
      tick();
      model_check();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule